// File: doc/BRIEF.md
# Register Context Transfer Sequencer

This block moves a processor register context between the register files and a word-addressed memory, one word per bus beat. A command picks the direction (save to memory or load from memory), the context size and the base word address. The small context holds the sixteen integer registers followed by the sixteen floating-point registers. The large context adds control registers 0 to 7 after those. Control registers 8 to 15 are never part of either context. The sequencer reads the register files through a combinational read port and writes them through a single write port. The memory side uses a request/acknowledge handshake.

The same engine runs the interrupt-entry macro when `irq_entry` is seen while idle. It saves the large context to the word address held in the task pointer (control register 2). It then loads the large context stored at byte address 0x84 (word 0x21). Last, it writes the old task pointer into integer register 14. A request for the large context while the core is in user mode is refused and flagged as illegal.

States: `ST_IDLE` (waits), `ST_XFER` (one word per acknowledged beat), `ST_LINK` (writes the link register during interrupt entry), `ST_FIN` (done pulse). Transitions:
- IDLE→XFER when a command or interrupt is accepted.
- XFER→XFER at the end of the interrupt save phase, which restarts as the interrupt load phase.
- XFER→LINK at the end of the interrupt load phase.
- XFER→FIN at the end of a plain command.
- LINK→FIN.
- FIN→IDLE.

Top module: `ctx_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `mem_req` and `rf_wr_en` are all low.
- R2: A save with `cmd_op`=0 and `cmd_full`=0 writes 32 words to addresses base+0 to base+31. Word k<16 is integer register k and word 16+k is floating-point register k. No other address is written.
- R3: A save with `cmd_full`=1 writes 40 words. Words base+32 to base+39 hold control registers 0 to 7. Control registers 8 to 15 are never read, so `rf_rd_sel`=2 with an index of 8 or more is never presented during a beat.
- R4: A load with `cmd_op`=1 reads 32 words (small context) or 40 words (large context) from base+k. Each word goes to the register of the same order as in R2/R3. Register-file select codes are 0 integer, 1 floating-point, 2 control. Registers outside the context are unchanged.
- R5: Exactly one word moves per cycle with `mem_req` and `mem_ack` both high. While `mem_req` is high without `mem_ack`, the address and direction hold.
- R6: `busy` rises the cycle after a command is accepted and stays high through a single-cycle `done`. It is low the cycle after `done`.
- R7: `cmd_valid` and `irq_entry` are ignored while `busy` is high.
- R8: A large-context command with `sup_mode`=0 starts no transfer. `illegal` pulses for exactly one cycle, the cycle after the command, and `busy` stays low.
- R9: On `irq_entry`, the large context is saved to word address `task_ptr[31:2]`. Then 40 words are loaded from word 0x21. Then integer register 14 is set to `task_ptr`, and `done` follows. `irq_entry` wins over a `cmd_valid` in the same cycle.
- R10: The image saved on interrupt entry holds the value integer register 14 had before the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_op | input | 1 | 0 save to memory, 1 load from memory |
| cmd_full | input | 1 | 0 small context, 1 large context |
| cmd_base | input | 30 | Base word address |
| sup_mode | input | 1 | Core is in supervisor mode |
| irq_entry | input | 1 | Start the interrupt-entry macro |
| task_ptr | input | 32 | Current value of control register 2 (byte address) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle refusal pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rf_rd_sel | output | 2 | Read file select |
| rf_rd_idx | output | 4 | Read register index |
| rf_rd_data | input | 32 | Read data (combinational) |
| rf_wr_en | output | 1 | Register write enable |
| rf_wr_sel | output | 2 | Write file select |
| rf_wr_idx | output | 4 | Write register index |
| rf_wr_data | output | 32 | Write data |

## Verification
A command driven before edge N is accepted at N. `busy` and `mem_req` are visible half a cycle later. `illegal` is valid only in the cycle after N. A load's register writes land at the edge that carries each `mem_ack`, and memory writes land at the same edge. `done` comes one cycle after the last beat, or two cycles after it in the interrupt macro because of the link write. The bench drives at falling edges and samples at the following falling edge. It polls `busy` every cycle until `done`, and only then compares the memory and register images, which are computed from seeded patterns. The sweep covers both directions, both context sizes and acknowledge latencies of 0 to 3 cycles.

// File: rtl/ctx_seq_pkg.sv
`timescale 1ns/1ps
package ctx_seq_pkg;
    typedef enum logic [1:0] {
        RF_INT = 2'd0,
        RF_FP  = 2'd1,
        RF_CR  = 2'd2
    } rf_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_LINK,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_IRQ_SAVE,
        PH_IRQ_LOAD
    } seq_phase_e;
endpackage

// File: rtl/ctx_word_map.sv
`timescale 1ns/1ps
// Maps a word position inside the context image to a register file and index.
module ctx_word_map
    import ctx_seq_pkg::*;
#(
    parameter int NINT  = 16,
    parameter int NFP   = 16,
    parameter int NCR   = 8,
    parameter int CW    = 6,
    parameter int IDX_W = 4
) (
    input  logic [CW-1:0]    word_pos,
    output rf_sel_e          file_sel,
    output logic [IDX_W-1:0] file_idx
);
    localparam logic [CW-1:0] INT_END = CW'(NINT);
    localparam logic [CW-1:0] FP_END  = CW'(NINT + NFP);

    always_comb begin
        if (word_pos < INT_END) begin
            file_sel = RF_INT;
            file_idx = IDX_W'(word_pos);
        end else if (word_pos < FP_END) begin
            file_sel = RF_FP;
            file_idx = IDX_W'(word_pos - INT_END);
        end else begin
            file_sel = RF_CR;
            file_idx = IDX_W'(word_pos - FP_END);
        end
    end
endmodule

// File: rtl/ctx_beat_ctr.sv
`timescale 1ns/1ps
// Word counter and address generator; restart has priority over advance.
module ctx_beat_ctr #(
    parameter int AW    = 30,
    parameter int CW    = 6,
    parameter int MAX_W = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [AW-1:0] restart_addr,
    input  logic          advance,
    output logic [CW-1:0] word_pos,
    output logic [AW-1:0] word_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_pos  <= '0;
            word_addr <= '0;
        end else if (restart) begin
            word_pos  <= '0;
            word_addr <= restart_addr;
        end else if (advance) begin
            word_pos  <= word_pos + 1'b1;
            word_addr <= word_addr + 1'b1;
        end
    end

    // The position never runs past one beyond the largest context.
    assert_pos_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(word_pos) <= MAX_W);
endmodule

// File: rtl/ctx_xfer_seq.sv
`timescale 1ns/1ps
module ctx_xfer_seq
    import ctx_seq_pkg::*;
#(
    parameter int DW           = 32,
    parameter int AW           = 30,
    parameter int NINT         = 16,
    parameter int NFP          = 16,
    parameter int NCR          = 8,
    parameter int LINK_REG     = 14,
    parameter logic [31:0] IRQ_CTX_BYTE = 32'h84,
    parameter int IDX_W        = $clog2((NINT > NFP) ? ((NINT > NCR) ? NINT : NCR)
                                                     : ((NFP > NCR) ? NFP : NCR))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_op,
    input  logic             cmd_full,
    input  logic [AW-1:0]    cmd_base,
    input  logic             sup_mode,
    input  logic             irq_entry,
    input  logic [DW-1:0]    task_ptr,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic [1:0]       rf_rd_sel,
    output logic [IDX_W-1:0] rf_rd_idx,
    input  logic [DW-1:0]    rf_rd_data,
    output logic             rf_wr_en,
    output logic [1:0]       rf_wr_sel,
    output logic [IDX_W-1:0] rf_wr_idx,
    output logic [DW-1:0]    rf_wr_data
);
    localparam int SMALL_W = NINT + NFP;
    localparam int LARGE_W = SMALL_W + NCR;
    localparam int CW      = $clog2(LARGE_W + 1);
    localparam logic [CW-1:0] SMALL_LAST = CW'(SMALL_W - 1);
    localparam logic [CW-1:0] LARGE_LAST = CW'(LARGE_W - 1);
    localparam logic [AW-1:0] IRQ_WADDR  = AW'(IRQ_CTX_BYTE >> 2);

    seq_state_e state_q, state_d;
    seq_phase_e phase_q, phase_d;
    logic       load_q, load_d;
    logic       large_q, large_d;
    logic [DW-1:0] link_q;
    logic       illegal_q;

    logic          ctr_restart;
    logic [AW-1:0] ctr_base;
    logic [CW-1:0] word_pos;
    logic [AW-1:0] word_addr;
    rf_sel_e       map_sel;
    logic [IDX_W-1:0] map_idx;

    logic idle, cmd_ok, cmd_refused, beat, last_beat;

    assign idle        = (state_q == ST_IDLE);
    assign cmd_ok      = idle && !irq_entry && cmd_valid && (sup_mode || !cmd_full);
    assign cmd_refused = idle && !irq_entry && cmd_valid && cmd_full && !sup_mode;
    assign beat        = (state_q == ST_XFER) && mem_ack;
    assign last_beat   = beat && (word_pos == (large_q ? LARGE_LAST : SMALL_LAST));

    ctx_beat_ctr #(
        .AW    (AW),
        .CW    (CW),
        .MAX_W (LARGE_W)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (ctr_restart),
        .restart_addr (ctr_base),
        .advance      (beat),
        .word_pos     (word_pos),
        .word_addr    (word_addr)
    );

    ctx_word_map #(
        .NINT  (NINT),
        .NFP   (NFP),
        .NCR   (NCR),
        .CW    (CW),
        .IDX_W (IDX_W)
    ) u_map (
        .word_pos (word_pos),
        .file_sel (map_sel),
        .file_idx (map_idx)
    );

    // Next state and transfer setup
    always_comb begin
        state_d     = state_q;
        phase_d     = phase_q;
        load_d      = load_q;
        large_d     = large_q;
        ctr_restart = 1'b0;
        ctr_base    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (irq_entry) begin
                    state_d     = ST_XFER;
                    phase_d     = PH_IRQ_SAVE;
                    load_d      = 1'b0;
                    large_d     = 1'b1;
                    ctr_restart = 1'b1;
                    ctr_base    = task_ptr[AW+1:2];
                end else if (cmd_ok) begin
                    state_d     = ST_XFER;
                    phase_d     = PH_CMD;
                    load_d      = cmd_op;
                    large_d     = cmd_full;
                    ctr_restart = 1'b1;
                    ctr_base    = cmd_base;
                end
            end
            ST_XFER: begin
                if (last_beat) begin
                    unique case (phase_q)
                        PH_IRQ_SAVE: begin
                            phase_d     = PH_IRQ_LOAD;
                            load_d      = 1'b1;
                            ctr_restart = 1'b1;
                            ctr_base    = IRQ_WADDR;
                        end
                        PH_IRQ_LOAD: state_d = ST_LINK;
                        default:     state_d = ST_FIN;
                    endcase
                end
            end
            ST_LINK: state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_CMD;
            load_q    <= 1'b0;
            large_q   <= 1'b0;
            link_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            phase_q   <= phase_d;
            load_q    <= load_d;
            large_q   <= large_d;
            illegal_q <= cmd_refused;
            if (idle && irq_entry) begin
                link_q <= task_ptr;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = !idle;
        done       = (state_q == ST_FIN);
        illegal    = illegal_q;
        mem_req    = (state_q == ST_XFER);
        mem_we     = (state_q == ST_XFER) && !load_q;
        mem_addr   = word_addr;
        mem_wdata  = rf_rd_data;
        rf_rd_sel  = map_sel;
        rf_rd_idx  = map_idx;
        if (state_q == ST_LINK) begin
            rf_wr_en   = 1'b1;
            rf_wr_sel  = RF_INT;
            rf_wr_idx  = IDX_W'(LINK_REG);
            rf_wr_data = link_q;
        end else begin
            rf_wr_en   = beat && load_q;
            rf_wr_sel  = map_sel;
            rf_wr_idx  = map_idx;
            rf_wr_data = mem_rdata;
        end
    end

    assert_done_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_done_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    assert_refuse_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_req));
    assert_refuse_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);
    assert_no_high_cr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && rf_rd_sel == RF_CR) |-> (int'(rf_rd_idx) < NCR));
    assert_write_only_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && mem_req) |-> (!mem_we && mem_ack));
    assert_ignore_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/tb_ctx_xfer_seq.sv
`timescale 1ns/1ps
module tb_ctx_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_op = 1'b0, cmd_full = 1'b0, sup_mode = 1'b1;
    logic [29:0] cmd_base = '0;
    logic        irq_entry = 1'b0;
    logic [31:0] task_ptr = '0;
    logic        busy, done, illegal, mem_req, mem_we, mem_ack = 1'b0;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
    logic [1:0]  rf_rd_sel, rf_wr_sel;
    logic [3:0]  rf_rd_idx, rf_wr_idx;
    logic        rf_wr_en;

    logic [31:0] mem [0:255];
    logic [31:0] rf  [0:63];

    int tests = 0, fails = 0, cycles = 0;
    int beats = 0, hold_err = 0, crhi = 0;
    int lat = 0, wcnt = 0;
    logic        hold_chk = 1'b0;
    logic [29:0] hold_addr = '0;

    int fill_kind = 0, fill_seed = 0, fill_base = 0;

    always #2.5 clk = ~clk;

    ctx_xfer_seq dut (.*);

    function automatic logic [31:0] pat(input int s, input int k);
        return 32'(s) * 32'h0101_0101 + 32'(k) * 32'h0001_0007 + 32'h0BAD_0000;
    endfunction

    assign rf_rd_data = rf[{rf_rd_sel, rf_rd_idx}];
    assign mem_rdata  = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (fill_kind == 1) begin
            for (int k = 0; k < 64; k++) rf[k] <= pat(fill_seed, k);
        end else if (fill_kind == 2) begin
            for (int a = 0; a < 256; a++) begin
                if (a >= fill_base && a < fill_base + 40) mem[a] <= pat(fill_seed, a - fill_base);
                else mem[a] <= 32'hDEAD_0000 | 32'(a);
            end
        end
        if (mem_req && mem_ack) begin
            beats <= beats + 1;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_we && rf_rd_sel == 2'd2 && rf_rd_idx >= 4'd8) crhi <= crhi + 1;
        end
        if (rf_wr_en) rf[{rf_wr_sel, rf_wr_idx}] <= rf_wr_data;
        if (mem_req && !mem_ack) begin
            hold_chk  <= 1'b1;
            hold_addr <= mem_addr;
            wcnt      <= wcnt + 1;
        end else begin
            hold_chk <= 1'b0;
            wcnt     <= 0;
        end
    end

    always @(negedge clk) begin
        if (hold_chk && (!mem_req || mem_addr != hold_addr)) hold_err <= hold_err + 1;
        mem_ack <= mem_req && (wcnt >= lat);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input int kind, input int seed, input int base);
        @(negedge clk);
        fill_kind = kind; fill_seed = seed; fill_base = base;
        @(negedge clk);
        fill_kind = 0;
    endtask

    // Waits for done; busy must stay high until then (R6).
    task automatic wait_done(input string req);
        int  n = 0;
        bit  gap = 0;
        while (!done && n < 3000) begin
            if (!busy) gap = 1;
            @(negedge clk);
            n++;
        end
        chk(!gap && done && busy, req, {30'b0, done, busy}, 32'h3);
        @(negedge clk);
        chk(!busy && !done, "R6 idle after done", {30'b0, done, busy}, 32'h0);
    endtask

    task automatic issue(input logic op, input logic full, input logic sup, input int base);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_full = full; sup_mode = sup; cmd_base = 30'(base);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        if (cycles > 150000) begin end
    end

    always @(posedge clk) begin
        if (cycles == 150000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int b0, n, seed, base, bad;
        fill(1, 0, 0);
        fill(2, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !illegal && !mem_req && !rf_wr_en, "R1 reset outputs",
            {27'b0, busy, done, illegal, mem_req, rf_wr_en}, 32'h0);

        // Sweep: latency x size x direction
        for (int l = 0; l < 4; l++) begin
            for (int f = 0; f < 2; f++) begin
                for (int o = 0; o < 2; o++) begin
                    lat  = l;
                    seed = l * 4 + f * 2 + o + 1;
                    base = 16 + 8 * l;
                    n    = f ? 40 : 32;
                    fill(1, seed, 0);
                    fill(2, seed + 50, base);
                    b0 = beats;
                    issue(o[0], f[0], (f == 0 && l == 2) ? 1'b0 : 1'b1, base);
                    chk(busy && mem_req, "R6 busy after accept", {30'b0, busy, mem_req}, 32'h3);
                    wait_done("R6 busy held until done");
                    chk(beats - b0 == n, "R5 one word per beat", 32'(beats - b0), 32'(n));
                    bad = 0;
                    if (o == 0) begin
                        for (int k = 0; k < n; k++) if (mem[base + k] != pat(seed, k)) bad++;
                        if (f == 0 && mem[base + 32] != pat(seed + 50, 32)) bad++;
                        if (f == 1 && mem[base + 40] != (32'hDEAD_0000 | 32'(base + 40))) bad++;
                        chk(bad == 0, f ? "R3 large save image" : "R2 small save image", 32'(bad), 32'h0);
                    end else begin
                        for (int k = 0; k < 64; k++) begin
                            if (k < n && rf[k] != pat(seed + 50, k)) bad++;
                            if (k >= n && rf[k] != pat(seed, k)) bad++;
                        end
                        chk(bad == 0, "R4 load image and untouched registers", 32'(bad), 32'h0);
                    end
                end
            end
        end
        chk(hold_err == 0, "R5 address held during stall", 32'(hold_err), 32'h0);
        chk(crhi == 0, "R3 control regs 8-15 never read", 32'(crhi), 32'h0);

        // R7: second command during a transfer is ignored
        lat = 1;
        fill(1, 90, 0);
        fill(2, 91, 192);
        b0 = beats;
        issue(1'b0, 1'b0, 1'b1, 128);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_full = 1'b1; cmd_base = 30'd192; irq_entry = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; irq_entry = 1'b0;
        wait_done("R6 busy held (R7 run)");
        chk(beats - b0 == 32, "R7 extra command ignored (beats)", 32'(beats - b0), 32'd32);
        bad = 0;
        for (int k = 0; k < 64; k++) if (rf[k] != pat(90, k)) bad++;
        chk(bad == 0, "R7 registers untouched by ignored load", 32'(bad), 32'h0);

        // R8: large context in user mode refused
        for (int o = 0; o < 2; o++) begin
            b0 = beats;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = o[0]; cmd_full = 1'b1; sup_mode = 1'b0; cmd_base = 30'd192;
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(illegal && !busy && !mem_req, "R8 refusal pulse",
                {29'b0, illegal, busy, mem_req}, 32'h4);
            @(negedge clk);
            chk(!illegal && !busy, "R8 pulse one cycle", {30'b0, illegal, busy}, 32'h0);
            repeat (4) @(negedge clk);
            chk(beats == b0, "R8 no bus activity", 32'(beats - b0), 32'h0);
        end
        sup_mode = 1'b1;

        // R9/R10: interrupt entry, with a competing command in the same cycle
        for (int l = 0; l < 3; l += 2) begin
            lat = l;
            fill(1, 70 + l, 0);
            fill(2, 71 + l, 33);
            task_ptr = 32'h0000_0140;
            b0 = beats;
            @(negedge clk);
            irq_entry = 1'b1;
            cmd_valid = 1'b1; cmd_op = 1'b0; cmd_full = 1'b0; cmd_base = 30'd192;
            @(negedge clk);
            irq_entry = 1'b0; cmd_valid = 1'b0;
            wait_done("R6 busy held (R9 run)");
            chk(beats - b0 == 80, "R9 save then load beats", 32'(beats - b0), 32'd80);
            bad = 0;
            for (int k = 0; k < 40; k++) if (mem[80 + k] != pat(70 + l, k)) bad++;
            chk(bad == 0, "R9 saved image at task pointer", 32'(bad), 32'h0);
            chk(mem[80 + 14] == pat(70 + l, 14), "R10 saved image keeps old r14",
                mem[80 + 14], pat(70 + l, 14));
            bad = 0;
            for (int k = 0; k < 64; k++) begin
                if (k < 40 && k != 14 && rf[k] != pat(71 + l, k)) bad++;
                if (k >= 40 && rf[k] != pat(70 + l, k)) bad++;
            end
            chk(bad == 0, "R9 interrupt context loaded", 32'(bad), 32'h0);
            chk(rf[14] == 32'h0000_0140, "R9 r14 holds old task pointer", rf[14], 32'h0000_0140);
            chk(mem[192] == 32'hDEAD_00C0, "R9 interrupt wins over command", mem[192], 32'hDEAD_00C0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule